// File: doc/BRIEF.md
# Parallel Converter Acquisition Sequencer

This block is the host-side controller for a successive-approximation converter with a parallel result bus, an active-low start strobe, a read strobe, a chip select, a shutdown request and a busy flag that is low while a conversion runs. It produces every strobe from a system clock, with all setup, pulse, wake-up and access intervals given as cycle-count parameters. It watches the busy flag, takes the result off the bus at the right moment for the chosen handshake style, and presents each sample on a valid/ready output.

Three handshake styles are supported. In the always-enabled style, chip select and read stay asserted and the result is taken as soon as busy is seen high again. In the split style, a read pulse follows the conversion and the bus is sampled after the access interval. In the combined style, read and start are the same strobe: while it is low the bus first shows the previous result and then the new one once busy returns high, so the sequencer keeps the strobe low until after that point. The sequencer also steps the converter into and out of its two power-down states, picking the state with the chip select level and waiting out the matching wake-up interval. A timeout watchdog reports a converter that never answers.

Top module: `adc_seq_top`

## Requirements
- R1: Chip select is low for at least CS_SETUP clock cycles before the start strobe falls.
- R2: In the always-enabled (mode 0) and split (mode 1 or 3) styles the start strobe stays low for exactly CONV_LOW cycles.
- R3: Two falling edges of the start strobe are never closer than PERIOD cycles.
- R4: In mode 0, chip select and read are held low outside power-down, and the sample delivered is the result the converter latched when busy rose.
- R5: In split mode the read strobe is pulsed low after busy rises and the bus is captured only after RD_ACCESS cycles of it, so the delivered sample is the new result.
- R6: In mode 2 read and start fall together and rise together, staying low until after busy has risen and RD_ACCESS cycles more, so the delivered sample is the new result, never the previous one left on the bus.
- R7: A sample held while smp_ready_i is low keeps smp_valid_o high and smp_data_o unchanged, and no new start strobe is issued until it is taken.
- R8: Power-down sets chip select to the requested level (low for the light state, high for the deep state), keeps it unchanged for at least CS_SETUP cycles before shutdown falls, and issues no start strobe while shutdown is low.
- R9: After shutdown is released, no start strobe falls for NAP_WAKE cycles (light state) or SLEEP_WAKE cycles (deep state).
- R10: If busy does not fall within BUSY_FALL_MAX cycles after the strobe-low interval, or does not rise within CONV_MAX cycles after falling, fault_o pulses high for one cycle, no sample is delivered, and the sequencer returns to idle.
- R11: During reset all converter strobes, chip select and shutdown are high, and smp_valid_o and fault_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Handshake style: 0 always-enabled, 2 combined strobe, 1 or 3 split read |
| enable_i | input | 1 | Run conversions back to back |
| pd_req_i | input | 1 | Request power-down; release to wake |
| pd_sleep_i | input | 1 | Power-down depth: 1 deep, 0 light |
| smp_ready_i | input | 1 | Downstream accepts a sample |
| adc_busy_i | input | 1 | Converter busy flag, low while converting |
| adc_data_i | input | DW | Converter result bus |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_conv_n_o | output | 1 | Start strobe, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_shdn_n_o | output | 1 | Shutdown request, active low |
| smp_valid_o | output | 1 | Sample available |
| smp_data_o | output | DW | Sample value |
| fault_o | output | 1 | One-cycle pulse on a conversion timeout |

## Verification
The assertions assume the busy flag only goes low in answer to a start strobe and returns high on its own, and that mode_i changes only while the sequencer is idle. The stimulus keeps to this: a converter model in the bench lowers busy a fixed short delay after a qualified strobe edge, holds it for a conversion time shorter than CONV_MAX, drives the bus only after the read has been low for an access time shorter than RD_ACCESS, and the mode is changed only after enable has been off long enough for any conversion to finish. The fault cases break the model on purpose and then reset it before normal traffic resumes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [1:0] MODE_FREE  = 2'd0;
  localparam logic [1:0] MODE_SPLIT = 2'd1;
  localparam logic [1:0] MODE_TIED  = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WFALL,
    ST_WRISE,
    ST_READ,
    ST_FAULT,
    ST_PDSET,
    ST_PD,
    ST_WAKE
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic conv_n;
    logic rd_n;
    logic shdn_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, conv_n: 1'b1, rd_n: 1'b1, shdn_n: 1'b1};

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_nx;

      always_comb begin
        sh_nx    = sh_q << 1;
        sh_nx[0] = d_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_nx;
      end

      assign q_o = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer #(
  parameter int PERIOD = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ready_o
);

  localparam int PW = $clog2(PERIOD + 1);
  localparam logic [PW-1:0] P_END = PW'(PERIOD);

  logic [PW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != P_END);
    cnt_nx = start_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= P_END;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign ready_o = (cnt_q == P_END);

  // R3: a start may only be issued once the throughput window has elapsed
  a_r3_start_paced: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ready_o);

endmodule

// File: rtl/adc_seq_slot.sv
module adc_seq_slot #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          free_o
);

  logic          valid_q, valid_nx, valid_en;
  logic [DW-1:0] data_q;

  always_comb begin
    valid_en = load_i || (valid_q && ready_i);
    valid_nx = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (valid_en) valid_q <= valid_nx;
      if (load_i)   data_q  <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign free_o  = !valid_q || ready_i;

  // R7: a stalled sample stays put
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));

  // R7: the controller never overwrites a sample that was not taken
  a_r7_load_free: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!valid_q || ready_i));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CS_SETUP      = 1,
  parameter int CONV_LOW      = 4,
  parameter int RD_ACCESS     = 5,
  parameter int NAP_WAKE      = 20,
  parameter int SLEEP_WAKE    = 500,
  parameter int BUSY_FALL_MAX = 10,
  parameter int CONV_MAX      = 230
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       enable_i,
  input  logic       pd_req_i,
  input  logic       pd_sleep_i,
  input  logic       busy_s_i,
  input  logic       pace_ok_i,
  input  logic       slot_free_i,
  output logic       start_o,
  output logic       load_o,
  output logic       fault_o,
  output pins_t      pins_o
);

  localparam int TMAX = imax(imax(imax(SLEEP_WAKE, NAP_WAKE), imax(CONV_MAX, BUSY_FALL_MAX)),
                             imax(imax(RD_ACCESS, CS_SETUP), CONV_LOW));
  localparam int CW = $clog2(TMAX + 2);
  localparam logic [CW-1:0] L_SETUP = CW'(CS_SETUP - 1);
  localparam logic [CW-1:0] L_LOW   = CW'(CONV_LOW - 1);
  localparam logic [CW-1:0] L_FALL  = CW'(BUSY_FALL_MAX - 1);
  localparam logic [CW-1:0] L_CONV  = CW'(CONV_MAX - 1);
  localparam logic [CW-1:0] L_READ  = CW'(RD_ACCESS);
  localparam logic [CW-1:0] L_NAP   = CW'(NAP_WAKE - 1);
  localparam logic [CW-1:0] L_SLEEP = CW'(SLEEP_WAKE - 1);

  seq_state_e    st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [1:0]    mode_q, mode_nx;
  logic          sleep_q, sleep_nx;
  logic          fault_q, fault_nx;
  pins_t         pins_q, pins_nx;
  logic          is_free, is_tied;

  assign is_free = (mode_q == MODE_FREE);
  assign is_tied = (mode_q == MODE_TIED);

  // next-state logic
  always_comb begin
    st_nx    = st_q;
    cnt_nx   = cnt_q + 1'b1;
    mode_nx  = mode_q;
    sleep_nx = sleep_q;
    fault_nx = 1'b0;
    start_o  = 1'b0;
    load_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_nx  = '0;
        mode_nx = mode_i;
        if (pd_req_i) begin
          st_nx    = ST_PDSET;
          sleep_nx = pd_sleep_i;
        end else if (enable_i && pace_ok_i && slot_free_i) begin
          st_nx = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt_q == L_SETUP) begin
          st_nx   = ST_STROBE;
          cnt_nx  = '0;
          start_o = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_q == L_LOW) begin
          st_nx  = ST_WFALL;
          cnt_nx = '0;
        end
      end
      ST_WFALL: begin
        if (!busy_s_i) begin
          st_nx  = ST_WRISE;
          cnt_nx = '0;
        end else if (cnt_q == L_FALL) begin
          st_nx = ST_FAULT;
        end
      end
      ST_WRISE: begin
        if (busy_s_i) begin
          cnt_nx = '0;
          if (is_free) begin
            load_o = 1'b1;
            st_nx  = ST_IDLE;
          end else begin
            st_nx = ST_READ;
          end
        end else if (cnt_q == L_CONV) begin
          st_nx = ST_FAULT;
        end
      end
      ST_READ: begin
        if (cnt_q == L_READ) begin
          load_o = 1'b1;
          st_nx  = ST_IDLE;
        end
      end
      ST_FAULT: begin
        fault_nx = 1'b1;
        st_nx    = ST_IDLE;
      end
      ST_PDSET: begin
        if (cnt_q == L_SETUP) begin
          st_nx  = ST_PD;
          cnt_nx = '0;
        end
      end
      ST_PD: begin
        cnt_nx = '0;
        if (!pd_req_i) st_nx = ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt_q == (sleep_q ? L_SLEEP : L_NAP)) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // converter pin levels for the state just entered
  always_comb begin
    pins_nx = PINS_IDLE;
    unique case (st_nx)
      ST_IDLE, ST_FAULT: begin
        pins_nx.cs_n = !is_free;
        pins_nx.rd_n = !is_free;
      end
      ST_SETUP: begin
        pins_nx.cs_n = 1'b0;
        pins_nx.rd_n = !is_free;
      end
      ST_STROBE: begin
        pins_nx.cs_n   = 1'b0;
        pins_nx.conv_n = 1'b0;
        pins_nx.rd_n   = !(is_free || is_tied);
      end
      ST_WFALL, ST_WRISE: begin
        pins_nx.cs_n   = 1'b0;
        pins_nx.conv_n = !is_tied;
        pins_nx.rd_n   = !(is_free || is_tied);
      end
      ST_READ: begin
        pins_nx.cs_n   = 1'b0;
        pins_nx.conv_n = !is_tied;
        pins_nx.rd_n   = 1'b0;
      end
      ST_PDSET, ST_WAKE: begin
        pins_nx.cs_n = sleep_nx;
      end
      ST_PD: begin
        pins_nx.cs_n   = sleep_nx;
        pins_nx.shdn_n = 1'b0;
      end
      default: pins_nx = PINS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= MODE_SPLIT;
      sleep_q <= 1'b0;
      fault_q <= 1'b0;
      pins_q  <= PINS_IDLE;
    end else begin
      st_q    <= st_nx;
      cnt_q   <= cnt_nx;
      mode_q  <= mode_nx;
      sleep_q <= sleep_nx;
      fault_q <= fault_nx;
      pins_q  <= pins_nx;
    end
  end

  assign pins_o  = pins_q;
  assign fault_o = fault_q;

  // checker state: length of the current strobe-low run
  logic [CW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run_q <= '0;
    else if (!pins_q.conv_n) low_run_q <= low_run_q + 1'b1;
    else                     low_run_q <= '0;
  end

  // R1: chip select already low in the cycle before the strobe falls
  a_r1_cs_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins_q.conv_n) |-> ($past(pins_q.cs_n) == 1'b0));

  // R2: strobe width in the non-combined styles
  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pins_q.conv_n) && !is_tied) |-> (low_run_q == CW'(CONV_LOW)));

  // R6: combined strobe moves read and start together
  a_r6_tied_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pins_q.conv_n) && is_tied) |-> $rose(pins_q.rd_n));

  // R8: chip select settled before shutdown falls
  a_r8_cs_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins_q.shdn_n) |-> $stable(pins_q.cs_n));

  // R8: no start strobe during power-down
  a_r8_no_strobe_down: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.shdn_n |-> pins_q.conv_n);

  // R10: fault is a single-cycle pulse
  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> !fault_q);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DW            = 14,
  parameter int SYNC_STAGES   = 2,
  parameter int CS_SETUP      = 1,
  parameter int CONV_LOW      = 4,
  parameter int PERIOD        = 250,
  parameter int RD_ACCESS     = 5,
  parameter int NAP_WAKE      = 20,
  parameter int SLEEP_WAKE    = 500,
  parameter int BUSY_FALL_MAX = 10,
  parameter int CONV_MAX      = 230
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          enable_i,
  input  logic          pd_req_i,
  input  logic          pd_sleep_i,
  input  logic          smp_ready_i,
  input  logic          adc_busy_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          adc_cs_n_o,
  output logic          adc_conv_n_o,
  output logic          adc_rd_n_o,
  output logic          adc_shdn_n_o,
  output logic          smp_valid_o,
  output logic [DW-1:0] smp_data_o,
  output logic          fault_o
);

  logic  busy_s;
  logic  pace_ok;
  logic  slot_free;
  logic  start;
  logic  load;
  pins_t pins;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (adc_busy_i),
    .q_o   (busy_s)
  );

  adc_seq_pacer #(.PERIOD(PERIOD)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .ready_o (pace_ok)
  );

  adc_seq_ctrl #(
    .CS_SETUP      (CS_SETUP),
    .CONV_LOW      (CONV_LOW),
    .RD_ACCESS     (RD_ACCESS),
    .NAP_WAKE      (NAP_WAKE),
    .SLEEP_WAKE    (SLEEP_WAKE),
    .BUSY_FALL_MAX (BUSY_FALL_MAX),
    .CONV_MAX      (CONV_MAX)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .enable_i    (enable_i),
    .pd_req_i    (pd_req_i),
    .pd_sleep_i  (pd_sleep_i),
    .busy_s_i    (busy_s),
    .pace_ok_i   (pace_ok),
    .slot_free_i (slot_free),
    .start_o     (start),
    .load_o      (load),
    .fault_o     (fault_o),
    .pins_o      (pins)
  );

  adc_seq_slot #(.DW(DW)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (adc_data_i),
    .ready_i (smp_ready_i),
    .valid_o (smp_valid_o),
    .data_o  (smp_data_o),
    .free_o  (slot_free)
  );

  assign adc_cs_n_o   = pins.cs_n;
  assign adc_conv_n_o = pins.conv_n;
  assign adc_rd_n_o   = pins.rd_n;
  assign adc_shdn_n_o = pins.shdn_n;

endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  localparam int DW = 14, CS_SETUP = 1, CONV_LOW = 4, PERIOD = 250, RD_ACCESS = 5;
  localparam int NAP_WAKE = 20, SLEEP_WAKE = 500, BUSY_FALL_MAX = 10, CONV_MAX = 230;
  localparam int BDLY = 2, CONVC = 150, ACC = 3;
  localparam logic [DW-1:0] GARB = 14'h2AAA;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic enable, pd_req, pd_sleep, ready;
  logic busy_m;
  logic [DW-1:0] bus;
  logic cs_n, conv_n, rd_n, shdn_n, valid, fault;
  logic [DW-1:0] sdata;

  always #5 clk = ~clk;

  adc_seq_top #(
    .DW(DW), .SYNC_STAGES(2), .CS_SETUP(CS_SETUP), .CONV_LOW(CONV_LOW), .PERIOD(PERIOD),
    .RD_ACCESS(RD_ACCESS), .NAP_WAKE(NAP_WAKE), .SLEEP_WAKE(SLEEP_WAKE),
    .BUSY_FALL_MAX(BUSY_FALL_MAX), .CONV_MAX(CONV_MAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .enable_i(enable), .pd_req_i(pd_req),
    .pd_sleep_i(pd_sleep), .smp_ready_i(ready), .adc_busy_i(busy_m), .adc_data_i(bus),
    .adc_cs_n_o(cs_n), .adc_conv_n_o(conv_n), .adc_rd_n_o(rd_n), .adc_shdn_n_o(shdn_n),
    .smp_valid_o(valid), .smp_data_o(sdata), .fault_o(fault)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  int popped = 0, pushed = 0, fall_cnt = 0, fault_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    if (m == 2'd0) return "R4";
    if (m == 2'd2) return "R6";
    return "R5";
  endfunction

  // converter model; hang_* and clr bend it for the fault cases
  bit hang_fall = 0, hang_rise = 0, clr = 0;
  bit conv_on;
  int tmr, rd_run;
  logic conv_p;
  logic [DW-1:0] latch_m, code_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_on <= 0; tmr <= 0; rd_run <= 0; conv_p <= 1'b1; busy_m <= 1'b1;
      latch_m <= 14'h0000; code_m <= 14'h0123;
    end else begin
      conv_p <= conv_n;
      rd_run <= (!cs_n && !rd_n) ? rd_run + 1 : 0;
      if (clr) begin
        conv_on <= 0; busy_m <= 1'b1;
      end else if (!conv_on) begin
        if (conv_p && !conv_n && !cs_n && shdn_n) begin conv_on <= 1; tmr <= 0; end
      end else begin
        tmr <= tmr + 1;
        if (tmr == BDLY && !hang_fall) busy_m <= 1'b0;
        if (tmr == BDLY + CONVC && !hang_fall && !hang_rise) begin
          busy_m  <= 1'b1;
          latch_m <= code_m;
          exp_q.push_back(code_m);
          pushed++;
          code_m  <= code_m + 14'd3001;
          conv_on <= 0;
        end
      end
    end
  end

  assign bus = (!cs_n && !rd_n && rd_run >= ACC) ? latch_m : GARB;

  // monitor: scoreboard pop and pin timing
  logic p_conv = 1, p_shdn = 1, p_cs = 1, p_rd = 1, p_valid = 0, p_ready = 0;
  logic [DW-1:0] p_data = '0;
  int cyc = 0, last_fall = -1, cs_run = 0, low_run = 0, shdn_rise = 0, wake_exp = 0;
  bit wake_pend = 0, strobe_in_pd = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (fault) fault_cnt++;
      if (valid && ready) begin
        if (exp_q.size() == 0) chk(0, mode_req(mode), int'(sdata), -1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(sdata == e, mode_req(mode), int'(sdata), int'(e));
        end
        popped++;
      end
      if (p_valid && !p_ready)
        chk(valid && sdata == p_data, "R7", int'(sdata), int'(p_data));
      if (p_conv && !conv_n) begin
        fall_cnt++;
        chk(!cs_n && cs_run >= CS_SETUP, "R1", cs_run, CS_SETUP);
        if (last_fall >= 0) chk(cyc - last_fall >= PERIOD, "R3", cyc - last_fall, PERIOD);
        last_fall = cyc;
        if (wake_pend) begin
          chk(cyc - shdn_rise >= wake_exp, "R9", cyc - shdn_rise, wake_exp);
          wake_pend = 0;
        end
        if (mode == 2'd0) chk(rd_n == 1'b0, "R4", rd_n, 0);
        if (mode == 2'd2) chk(rd_n == 1'b0, "R6", rd_n, 0);
        chk(!(p_valid && !p_ready), "R7", p_valid, 0);
      end
      if (!p_conv && conv_n) begin
        if (mode == 2'd2) chk(rd_n && !p_rd, "R6", rd_n, 1);
        else chk(low_run == CONV_LOW, "R2", low_run, CONV_LOW);
      end
      if (p_shdn && !shdn_n) begin
        chk(cs_n == pd_sleep && cs_n == p_cs, "R8", cs_n, pd_sleep);
        wake_exp = cs_n ? SLEEP_WAKE : NAP_WAKE;
      end
      if (!shdn_n && !conv_n) strobe_in_pd = 1;
      if (!p_shdn && shdn_n) begin
        chk(!strobe_in_pd, "R8", strobe_in_pd, 0);
        shdn_rise = cyc; wake_pend = 1;
      end
      cs_run  = cs_n ? 0 : cs_run + 1;
      low_run = conv_n ? 0 : low_run + 1;
      p_conv = conv_n; p_shdn = shdn_n; p_cs = cs_n; p_rd = rd_n;
      p_valid = valid; p_ready = ready; p_data = sdata;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wait_samples(input int n);
    int target;
    target = popped + n;
    while (popped < target) @(posedge clk);
  endtask

  task automatic run_style(input logic [1:0] m, input int n);
    mode = m;
    repeat (4) @(posedge clk);
    enable = 1'b1;
    wait_samples(n);
    enable = 1'b0;
    repeat (400) @(posedge clk);
  endtask

  task automatic power_cycle(input bit deep);
    pd_sleep = deep;
    pd_req   = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(shdn_n == 1'b0 && cs_n == deep, "R8", {shdn_n, cs_n}, {1'b0, deep});
    pd_req = 1'b0;
    enable = 1'b1;
    wait_samples(2);
    enable = 1'b0;
    repeat (400) @(posedge clk);
  endtask

  task automatic fault_case(input bit on_fall);
    int f0, p0;
    f0 = fault_cnt; p0 = pushed;
    hang_fall = on_fall; hang_rise = !on_fall;
    enable = 1'b1;
    for (int i = 0; i < 2000 && fault_cnt == f0; i++) @(posedge clk);
    enable = 1'b0;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(fault_cnt > f0, "R10", fault_cnt - f0, 1);
    chk(pushed == p0 && !valid, "R10", int'(valid), 0);
    hang_fall = 0; hang_rise = 0; clr = 1;
    @(posedge clk); @(posedge clk);
    clr = 0;
    repeat (300) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'd1; enable = 0; pd_req = 0; pd_sleep = 0; ready = 1;
    repeat (3) @(negedge clk);
    chk(cs_n && conv_n && rd_n && shdn_n, "R11", {cs_n, conv_n, rd_n, shdn_n}, 15);
    chk(!valid && !fault, "R11", {valid, fault}, 0);
    @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    run_style(2'd1, 4);   // R5 split read
    run_style(2'd0, 4);   // R4 always-enabled
    @(negedge clk);
    chk(cs_n == 0 && rd_n == 0, "R4", {cs_n, rd_n}, 0);
    run_style(2'd2, 4);   // R6 combined strobe
    mode = 2'd1;

    begin : stall_R7
      int f0;
      ready = 1'b0;
      f0 = fall_cnt;
      enable = 1'b1;
      repeat (1500) @(posedge clk);
      @(negedge clk);
      chk(valid == 1'b1, "R7", valid, 1);
      chk(fall_cnt - f0 == 1, "R7", fall_cnt - f0, 1);
      ready = 1'b1;
      wait_samples(1);
      enable = 1'b0;
      repeat (400) @(posedge clk);
    end

    power_cycle(1'b0);    // R8/R9 light
    power_cycle(1'b1);    // R8/R9 deep
    fault_case(1'b1);     // R10 busy never falls
    fault_case(1'b0);     // R10 busy never rises
    run_style(2'd1, 2);   // recovery after faults

    @(negedge clk);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    chk(!wake_pend, "R9", wake_pend, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", popped, pushed);
      summary();
      $finish;
    end
  end

endmodule